// File: doc/BRIEF.md
# Console I/O Register Block

This block sits on the data bus of a 16-bit, word-addressed processor and responds to five fixed addresses that form a console: a keyboard status word, a keyboard character, a display status word, a display character and a machine control word. Every other address is handed on to main memory. Reads are combinational in the cycle of the request. Writes and the side effects of reads take hold at the next rising clock edge.

Characters arrive from a terminal over a byte stream with a valid/ready handshake. The block takes a byte only while no unread character is waiting, so `kbd_ready` is low whenever the keyboard flag is set. That back-pressure lasts until software reads the keyboard character register. Characters leave on a second valid/ready byte stream. A write to the display character register starts a transfer. `disp_valid` and `disp_data` then stay fixed until the terminal raises `disp_ready`. While a transfer is pending, the display status reports busy and further writes are dropped. Bit 15 of the machine control word drives `run`. When software clears that bit, the core stops issuing instructions.

Top module: `console_regs`

## Requirements
- R1: With `bus_req` high, `io_hit` is 1 exactly when `bus_addr` is one of 0xFE00, 0xFE02, 0xFE04, 0xFE06 or 0xFFFE, and `mem_sel` is 1 exactly when it is none of them. Both outputs are 0 while `bus_req` is low.
- R2: A byte on the keyboard stream is accepted on an edge where `kbd_valid` and `kbd_ready` are both 1. After that edge, a read of 0xFE00 returns 0x8000 and `kbd_ready` is 0. `kbd_ready` equals the inverse of keyboard-status bit 15.
- R3: A read of 0xFE02 returns the last accepted byte in bits 7:0. At the edge that ends such a read, the keyboard flag clears, unless a new byte is accepted at that same edge. A read of 0xFE00 leaves the flag unchanged.
- R4: A write to 0xFE06 while display status bit 15 is 1 captures `bus_wdata[7:0]`. After that edge, `disp_valid` is 1, `disp_data` is the captured byte, and a read of 0xFE04 returns 0x0000.
- R5: While `disp_valid` is 1 and `disp_ready` is 0, `disp_valid` and `disp_data` hold. After an edge with both high, `disp_valid` is 0 and a read of 0xFE04 returns 0x8000.
- R6: A write to 0xFE06 while a transfer is pending has no effect on `disp_data`.
- R7: A write to 0xFFFE sets `run` to `bus_wdata[15]` from the next cycle on. A read of 0xFFFE returns `run` in bit 15.
- R8: Reads of 0xFE02 and 0xFE06 return zero in bits 15:8. Reads of 0xFE00, 0xFE04 and 0xFFFE return zero in bits 14:0.
- R9: After reset, the keyboard flag is 0 (`kbd_ready`=1), the display is idle (`disp_valid`=0, status bit 15 = 1), and `run` is 1.
- R10: `bus_rdata` is 0 for writes and for unmapped reads. Writes to 0xFE00, 0xFE02, 0xFE04 and unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the request cycle |
| io_hit | output | 1 | Access claimed by this block |
| mem_sel | output | 1 | Access passed on to main memory |
| kbd_valid | input | 1 | Keyboard byte offered |
| kbd_data | input | 8 | Keyboard byte |
| kbd_ready | output | 1 | Keyboard byte can be taken |
| disp_valid | output | 1 | Display byte offered |
| disp_data | output | 8 | Display byte |
| disp_ready | input | 1 | Terminal takes the display byte |
| run | output | 1 | Machine control bit 15; 0 halts the core |

## Verification
The assertions assume that the terminal keeps `kbd_valid` and `kbd_data` steady until a byte is taken, and that bus inputs only change away from the rising edge. The stimulus meets both assumptions. It holds an offered keyboard byte until the model shows it was accepted, and it changes every input only on the falling edge. Random traffic is weighted toward the five decoded addresses. Random `disp_ready` creates long pending windows, so writes arrive both while the display is busy and while it is idle. Keyboard reads land both before and after a byte arrives.

// File: rtl/console_pkg.sv
package console_pkg;
  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_KSTAT = 3'd1,
    SEL_KDATA = 3'd2,
    SEL_DSTAT = 3'd3,
    SEL_DDATA = 3'd4,
    SEL_CTRL  = 3'd5
  } reg_sel_e;

  localparam int NUM_REGS = 5;
endpackage

// File: rtl/console_decode.sv
module console_decode
  import console_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KSTAT_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] KDATA_ADDR = 16'hFE02,
  parameter logic [ADDR_W-1:0] DSTAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DDATA_ADDR = 16'hFE06,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'hFFFE
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              hit,
  output logic              pass
);
  localparam logic [ADDR_W-1:0] MAP [NUM_REGS] =
    '{KSTAT_ADDR, KDATA_ADDR, DSTAT_ADDR, DDATA_ADDR, CTRL_ADDR};

  logic [NUM_REGS-1:0] match;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
    assign match[i] = (addr == MAP[i]);
  end

  always_comb begin
    sel = SEL_NONE;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (match[i]) sel = reg_sel_e'(3'(i + 1));
    end
  end

  assign hit  = req && (match != '0);
  assign pass = req && (match == '0);
endmodule

// File: rtl/console_kbd.sv
module console_kbd #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              consume,
  output logic              flag,
  output logic [CHAR_W-1:0] char_q
);
  logic take;
  assign in_ready = !flag;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      char_q <= '0;
    end else if (take) begin
      flag   <= 1'b1;
      char_q <= in_data;
    end else if (consume) begin
      flag   <= 1'b0;
    end
  end

  AST_KBD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> flag && char_q == $past(in_data)); // R2
  AST_KBD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    consume && !in_valid |=> !flag); // R3
endmodule

// File: rtl/console_disp.sv
module console_disp #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_char,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready
);
  logic load;
  assign load = wr_stb && !out_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= wr_char;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R5
  AST_DISP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid); // R5
  AST_DISP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && wr_stb |=> $stable(out_data)); // R6
endmodule

// File: rtl/console_regs.sv
module console_regs
  import console_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              io_hit,
  output logic              mem_sel,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_data,
  output logic              kbd_ready,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_data,
  input  logic              disp_ready,
  output logic              run
);
  localparam int FLAG_BIT = DATA_W - 1;
  localparam int PAD_W    = DATA_W - CHAR_W;

  reg_sel_e          sel;
  logic              rd_acc, wr_acc;
  logic              k_flag;
  logic [CHAR_W-1:0] k_char;
  logic              wdata_unused;

  assign wdata_unused = ^bus_wdata[FLAG_BIT-1:CHAR_W];

  console_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req(bus_req), .addr(bus_addr), .sel(sel), .hit(io_hit), .pass(mem_sel)
  );

  assign rd_acc = io_hit && !bus_we;
  assign wr_acc = io_hit && bus_we;

  console_kbd #(.CHAR_W(CHAR_W)) u_kbd (
    .clk(clk), .rst_n(rst_n),
    .in_valid(kbd_valid), .in_data(kbd_data), .in_ready(kbd_ready),
    .consume(rd_acc && sel == SEL_KDATA),
    .flag(k_flag), .char_q(k_char)
  );

  console_disp #(.CHAR_W(CHAR_W)) u_disp (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(wr_acc && sel == SEL_DDATA), .wr_char(bus_wdata[CHAR_W-1:0]),
    .out_valid(disp_valid), .out_data(disp_data), .out_ready(disp_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         run <= 1'b1;
    else if (wr_acc && sel == SEL_CTRL) run <= bus_wdata[FLAG_BIT];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      unique case (sel)
        SEL_KSTAT: bus_rdata[FLAG_BIT] = k_flag;
        SEL_KDATA: bus_rdata = {{PAD_W{1'b0}}, k_char};
        SEL_DSTAT: bus_rdata[FLAG_BIT] = !disp_valid;
        SEL_DDATA: bus_rdata = {{PAD_W{1'b0}}, disp_data};
        SEL_CTRL:  bus_rdata[FLAG_BIT] = run;
        default:   bus_rdata = '0;
      endcase
    end
  end

  AST_RUN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && sel == SEL_CTRL |=> run == $past(bus_wdata[FLAG_BIT])); // R7
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel |-> bus_rdata == '0); // R10
  AST_STATUS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && (sel == SEL_KSTAT || sel == SEL_CTRL) |-> bus_rdata[FLAG_BIT-1:0] == '0); // R8
endmodule

// File: tb/console_regs_bench.sv
module console_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic io_hit, mem_sel;
  logic kbd_valid = 1'b0, kbd_ready;
  logic [7:0] kbd_data = '0, disp_data;
  logic disp_valid, disp_ready = 1'b0, run;

  always #2 clk = ~clk;

  console_regs u_console_regs (
    .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .io_hit, .mem_sel, .kbd_valid, .kbd_data, .kbd_ready,
    .disp_valid, .disp_data, .disp_ready, .run
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_kflag = 0, m_dpend = 0, m_run = 1, k_taken = 0;
  logic [7:0] m_kchar = '0, m_dchar = '0;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [15:0] a);
    return a == 16'hFE00 || a == 16'hFE02 || a == 16'hFE04 || a == 16'hFE06 || a == 16'hFFFE;
  endfunction

  function automatic logic [15:0] exp_read(input bit rq, input bit we, input logic [15:0] a);
    if (!rq || we) return 16'h0;
    case (a)
      16'hFE00: return {m_kflag, 15'h0};
      16'hFE02: return {8'h0, m_kchar};
      16'hFE04: return {~m_dpend, 15'h0};
      16'hFE06: return {8'h0, m_dchar};
      16'hFFFE: return {m_run, 15'h0};
      default:  return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    case (a)
      16'hFE00: return "R2";
      16'hFE02: return "R3";
      16'hFE04: return "R4";
      16'hFE06: return "R8";
      16'hFFFE: return "R7";
      default:  return "R10";
    endcase
  endfunction

  task automatic step(input bit rq, input bit we, input logic [15:0] a, input logic [15:0] wd,
                      input bit kv, input logic [7:0] kd, input bit dr);
    bit kacc, dacc, dwr;
    @(negedge clk);
    bus_req = rq; bus_we = we; bus_addr = a; bus_wdata = wd;
    kbd_valid = kv; kbd_data = kd; disp_ready = dr;
    #1;
    chk(bus_rdata, exp_read(rq, we, a), tag_of(a));
    chk({15'h0, io_hit}, {15'h0, rq && mapped(a)}, "R1");
    chk({15'h0, mem_sel}, {15'h0, rq && !mapped(a)}, "R1");
    chk({15'h0, kbd_ready}, {15'h0, ~m_kflag}, "R2");
    chk({15'h0, disp_valid}, {15'h0, m_dpend}, "R5");
    if (m_dpend) chk({8'h0, disp_data}, {8'h0, m_dchar}, "R6");
    chk({15'h0, run}, {15'h0, m_run}, "R7");
    kacc = kv && !m_kflag;
    dacc = m_dpend && dr;
    dwr  = rq && we && a == 16'hFE06 && !m_dpend;
    @(posedge clk);
    if (kacc) begin m_kflag = 1; m_kchar = kd; end
    else if (rq && !we && a == 16'hFE02) m_kflag = 0;
    if (dacc) m_dpend = 0;
    if (dwr) begin m_dpend = 1; m_dchar = wd[7:0]; end
    if (rq && we && a == 16'hFFFE) m_run = wd[15];
    k_taken = kacc;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit kv;
    logic [7:0] kd;
    logic [15:0] a;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk({15'h0, kbd_ready}, 16'h1, "R9");
    chk({15'h0, disp_valid}, 16'h0, "R9");
    chk({15'h0, run}, 16'h1, "R9");
    step(1, 0, 16'hFE04, 0, 0, 0, 0);                  // R9 display idle
    // directed keyboard: R2, R3
    step(1, 0, 16'hFE02, 0, 1, 8'h41, 0);
    step(1, 0, 16'hFE00, 0, 1, 8'h42, 0);              // held off, flag stays
    step(1, 1, 16'hFE00, 16'h0000, 1, 8'h42, 0);       // R10 ignored write
    step(1, 0, 16'hFE02, 0, 1, 8'h42, 0);              // returns 0x0041, clears
    step(1, 0, 16'hFE00, 0, 0, 0, 0);
    // directed display: R4, R5, R6
    step(1, 1, 16'hFE06, 16'hABCD, 0, 0, 0);
    step(1, 0, 16'hFE04, 0, 0, 0, 0);
    step(1, 1, 16'hFE06, 16'h0011, 0, 0, 0);           // dropped
    step(0, 0, 16'h0000, 0, 0, 0, 1);
    step(1, 0, 16'hFE04, 0, 0, 0, 0);
    // directed control: R7
    step(1, 1, 16'hFFFE, 16'h7FFF, 0, 0, 0);
    step(1, 0, 16'hFFFE, 0, 0, 0, 0);
    step(1, 1, 16'hFFFE, 16'h8000, 0, 0, 0);
    step(1, 0, 16'h3000, 0, 0, 0, 0);                  // R10 unmapped
    // constrained random
    kv = 0; kd = '0;
    for (int i = 0; i < 3000; i++) begin
      if (!kv) begin kv = ($urandom % 3) == 0; kd = 8'($urandom); end
      case ($urandom % 6)
        0: a = 16'hFE00;
        1: a = 16'hFE02;
        2: a = 16'hFE04;
        3: a = 16'hFE06;
        4: a = 16'hFFFE;
        default: a = 16'($urandom);
      endcase
      step(($urandom % 4) != 0, ($urandom % 2) == 0, a, 16'($urandom),
           kv, kd, ($urandom % 4) == 0);
      if (k_taken) kv = 0;
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule